// File: doc/BRIEF.md
# Buffered Serial Transmitter with Completion Flag

This block turns bytes into asynchronous serial frames. A host writes a byte into a one-entry holding register. At a frame boundary the byte moves into a frame shifter, and the holding register is then free to take the next byte while the current frame is still going out. Bit timing comes from an external baud-enable pulse. One pulse lasts one bit period, and the block never changes its line output between pulses. Per frame the host can select 5 to 8 data bits, no parity, even parity or odd parity, and one or two stop bits.

Two flags report progress. The first shows that the holding register is empty. The second is a completion flag. It is raised only when the shifter has finished a frame and no further byte is waiting. A host that has to turn a shared line around uses it to know when the last stop bit has gone out. Each flag has its own interrupt request, gated by a per-source enable and a global enable. The completion flag clears when its interrupt is acknowledged or when the host writes a one to clear it.

Switching the transmitter off is deferred. A frame in flight and a byte still waiting in the holding register are both sent first. Only then does the block drop its output-enable and release the line.

Top module: `buf_uart_tx`

## Requirements
- R1: A frame is one low start bit, then N data bits sent least significant bit first, then an optional parity bit, then one stop bit (two_stop=0) or two stop bits (two_stop=1), all stop bits high. N = 5 + data_bits_sel (sel 0..3 gives 5..8). Data bits above N are discarded. The line idles high between frames.
- R2: When par_en=1, a parity bit goes after the last data bit and before the first stop bit. With par_odd=0 the N data bits plus the parity bit hold an even number of ones. With par_odd=1 they hold an odd number.
- R3: The line output changes only in the clock cycle that follows a cycle with baud_tick high. Each frame bit lasts exactly one baud_tick period. A new frame starts only on a baud_tick when the shifter is idle or is ending its last stop bit, so back-to-back frames have no gap.
- R4: A write to the holding register is accepted only when the register is empty and tx_enable=1. A write while a byte is already held, or while tx_enable=0, is ignored: no byte is stored and no frame results.
- R5: buf_empty is 1 after reset. It goes to 0 in the cycle after an accepted write and returns to 1 when the byte moves into the shifter.
- R6: tx_done sets when the last stop bit of a frame ends and no byte is waiting in the holding register. It stays 0 across the boundary between back-to-back frames. It is 0 after reset.
- R7: tx_done clears on a done_ack pulse and also on a done_clr_wr pulse.
- R8: irq_done is the registered AND of tx_done, done_irq_en and global_irq_en, one cycle late.
- R9: irq_empty is the registered AND of buf_empty, empty_irq_en and global_irq_en. It is a level that stays high for as long as the register is empty and both enables are set.
- R10: After tx_enable falls, the frame in flight and any byte already held are both sent in full, and txd_oe stays 1 until they are done.
- R11: Once the transmitter has really stopped, txd_oe is 0 and txd is 1. This is also the state after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_enable | input | 1 | Transmitter enable request |
| par_en | input | 1 | Insert a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| data_bits_sel | input | 2 | Data bits per frame minus 5 |
| two_stop | input | 1 | 1 = two stop bits |
| empty_irq_en | input | 1 | Enable for the buffer-empty interrupt |
| done_irq_en | input | 1 | Enable for the completion interrupt |
| global_irq_en | input | 1 | Global interrupt enable |
| wr_data_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| done_clr_wr | input | 1 | Write-one strobe that clears tx_done |
| done_ack | input | 1 | Completion interrupt acknowledge |
| txd | output | 1 | Serial line output |
| txd_oe | output | 1 | Line output-enable |
| buf_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Completion flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Completion interrupt request |

## Verification
The hardest case to reach is the frame boundary with a byte already waiting. Two writes have to land so that the second one fills the holding register while the first frame is still on the line, and a third write has to hit the full register. The bench gets there by writing one byte, waiting for buf_empty to rise again (which shows the byte has moved to the shifter), and then writing two more bytes at once. A serial receiver model in the bench, locked to the baud pulses it generates, decodes every frame. The bench checks that exactly two frames arrive, that tx_done stays low across the seam between them, and that the deferred disable runs the same back-to-back path before it drops txd_oe.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // data bits carried by a frame for a given width selector
  function automatic int frame_data_bits(input int data_w, input int sel_w, input int sel);
    return data_w - (1 << sel_w) + 1 + sel;
  endfunction
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_allow,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic accept;
  assign accept = wr_en && wr_allow && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (accept) begin
      full <= 1'b1;
      data <= wr_data;
    end
  end

  // R4: a write into a held byte leaves it untouched
  assert_full_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !take) |=> (full && $stable(data)));
  // R5: handing the byte to the shifter frees the register
  assert_take_empties_R5: assert property (@(posedge clk) disable iff (rst)
    take |=> !full);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              can_load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [SEL_W-1:0]  nbits_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              txd,
  output logic              busy,
  output logic              take,
  output logic              frame_end
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sreg, frame;
  logic [DATA_W-1:0]  masked;
  logic [CNT_W-1:0]   left, flen;
  logic               par_bit, slot;
  int                 nbits;

  always_comb begin
    nbits = frame_data_bits(DATA_W, SEL_W, int'(nbits_sel));
    for (int i = 0; i < DATA_W; i++) masked[i] = (i < nbits) ? ld_data[i] : 1'b0;
    par_bit = (^masked) ^ par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) if (i < nbits) frame[i+1] = masked[i];
    for (int i = 0; i < FRAME_W; i++) if (par_en && (i == nbits + 1)) frame[i] = par_bit;
    flen = CNT_W'(nbits + 2 + int'(par_en) + int'(two_stop));
  end

  assign slot      = !busy || (left == '0);
  assign take      = tick && slot && can_load;
  assign frame_end = tick && busy && (left == '0) && !can_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '1;
      txd  <= 1'b1;
      busy <= 1'b0;
      left <= '0;
    end else if (take) begin
      txd  <= frame[0];
      sreg <= {1'b1, frame[FRAME_W-1:1]};
      left <= flen - 1'b1;
      busy <= 1'b1;
    end else if (tick && busy) begin
      if (left != '0) begin
        txd  <= sreg[0];
        sreg <= {1'b1, sreg[FRAME_W-1:1]};
        left <= left - 1'b1;
      end else begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end
    end
  end

  // R3: the line moves only after a baud pulse
  assert_txd_moves_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd));
  // R1: a finished frame leaves the line idle high
  assert_idle_high_after_frame_R1: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (!busy && txd));
endmodule

// File: rtl/buf_uart_tx.sv
module buf_uart_tx #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              tx_enable,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [SEL_W-1:0]  data_bits_sel,
  input  logic              two_stop,
  input  logic              empty_irq_en,
  input  logic              done_irq_en,
  input  logic              global_irq_en,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              done_clr_wr,
  input  logic              done_ack,
  output logic              txd,
  output logic              txd_oe,
  output logic              buf_empty,
  output logic              tx_done,
  output logic              irq_empty,
  output logic              irq_done
);
  logic              buf_full, take, busy, frame_end, active, done_set;
  logic [DATA_W-1:0] buf_data;

  tx_hold_buf #(.DATA_W(DATA_W)) hold_i (
    .clk(clk), .rst(rst), .wr_en(wr_data_en), .wr_allow(tx_enable),
    .wr_data(wr_data), .take(take), .full(buf_full), .data(buf_data)
  );

  tx_frame_shifter #(.DATA_W(DATA_W), .SEL_W(SEL_W)) shift_i (
    .clk(clk), .rst(rst), .tick(baud_tick), .can_load(buf_full && active),
    .ld_data(buf_data), .nbits_sel(data_bits_sel), .par_en(par_en),
    .par_odd(par_odd), .two_stop(two_stop), .txd(txd), .busy(busy),
    .take(take), .frame_end(frame_end)
  );

  assign done_set  = frame_end && !buf_full;
  assign txd_oe    = active;
  assign buf_empty = !buf_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      tx_done   <= 1'b0;
      irq_empty <= 1'b0;
      irq_done  <= 1'b0;
    end else begin
      active <= tx_enable || (active && (busy || buf_full));
      if (done_set)                  tx_done <= 1'b1;
      else if (done_ack || done_clr_wr) tx_done <= 1'b0;
      irq_done  <= tx_done && done_irq_en && global_irq_en;
      irq_empty <= !buf_full && empty_irq_en && global_irq_en;
    end
  end

  // R10: the line stays driven while a frame is in flight
  assert_oe_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> txd_oe);
  // R10: release only once nothing is left and the enable is off
  assert_release_deferred_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(txd_oe) |-> $past(!busy && !buf_full && !tx_enable));
  // R11: a released line reads high
  assert_released_line_high_R11: assert property (@(posedge clk) disable iff (rst)
    !txd_oe |-> txd);
  // R6: completion is only raised with the shifter idle
  assert_done_rise_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> !busy);
  // R8: completion request follows the flag and both enables
  assert_irq_done_R8: assert property (@(posedge clk) disable iff (rst)
    (tx_done && done_irq_en && global_irq_en) |=> irq_done);
  // R9: empty request is a level while empty and enabled
  assert_irq_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (buf_empty && empty_irq_en && global_irq_en) |=> irq_empty);
endmodule

// File: tb/buf_uart_tx_tb_top.sv
module buf_uart_tx_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b0;
  logic tx_enable = 0, par_en = 0, par_odd = 0, two_stop = 0;
  logic [1:0] data_bits_sel = 2'd3;
  logic empty_irq_en = 0, done_irq_en = 0, global_irq_en = 0;
  logic wr_data_en = 0, done_clr_wr = 0, done_ack = 0;
  logic [7:0] wr_data = '0;
  logic txd, txd_oe, buf_empty, tx_done, irq_empty, irq_done;

  int total = 0, bad = 0;
  int tcnt = 0;
  int rx_pos = 0;
  int rx_cnt = 0;
  logic [11:0] rx_bits;
  logic [11:0] rx_frame [0:31];
  int rx_len [0:31];

  always #2.5 clk = ~clk;

  buf_uart_tx dut_i (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_enable(tx_enable),
    .par_en(par_en), .par_odd(par_odd), .data_bits_sel(data_bits_sel),
    .two_stop(two_stop), .empty_irq_en(empty_irq_en), .done_irq_en(done_irq_en),
    .global_irq_en(global_irq_en), .wr_data_en(wr_data_en), .wr_data(wr_data),
    .done_clr_wr(done_clr_wr), .done_ack(done_ack), .txd(txd), .txd_oe(txd_oe),
    .buf_empty(buf_empty), .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done)
  );

  function automatic int flen_now();
    return 1 + 5 + int'(data_bits_sel) + int'(par_en) + 1 + int'(two_stop);
  endfunction

  // baud pulse every 8 cycles plus a mid-bit sampling receiver model
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 8;
    baud_tick = (tcnt == 0);
    if (tcnt == 4) begin
      if (rx_pos == 0) begin
        if (txd_oe && !txd) begin
          rx_bits = '0;
          rx_pos = 1;
        end
      end else begin
        rx_bits[rx_pos] = txd;
        rx_pos++;
        if (rx_pos == flen_now()) begin
          if (rx_cnt < 32) begin
            rx_frame[rx_cnt] = rx_bits;
            rx_len[rx_cnt] = rx_pos;
          end
          rx_cnt++;
          rx_pos = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_data = b; wr_data_en = 1'b1;
    @(negedge clk);
    wr_data_en = 1'b0;
  endtask

  task automatic wait_rx(input int target, input string req);
    int n = 0;
    while (rx_cnt < target && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(rx_cnt >= target, req, rx_cnt, target);
  endtask

  // expected frame computed from the requirement text
  task automatic check_frame(input int k, input logic [7:0] d, input string req);
    logic [11:0] exp;
    logic [11:0] got;
    int nb, len, ones;
    nb = 5 + int'(data_bits_sel);
    exp = '1;
    exp[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      exp[1+i] = d[i];
      if (d[i]) ones++;
    end
    if (par_en) exp[1+nb] = par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
    len = 1 + nb + int'(par_en) + 1 + int'(two_stop);
    for (int i = 0; i < 12; i++) if (i >= len) exp[i] = 1'b0;
    got = rx_frame[k];
    check(got == exp && rx_len[k] == len, req, int'(got), int'(exp));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check(!txd_oe && txd, "R11 reset line", {txd_oe, txd}, 2'b01);
    check(buf_empty == 1'b1, "R5 reset empty", buf_empty, 1);
    check(tx_done == 1'b0, "R6 reset done", tx_done, 0);
    check(!irq_empty && !irq_done, "R8 R9 reset irq", {irq_empty, irq_done}, 0);
  endtask

  task automatic t_basic;
    int base = rx_cnt;
    data_bits_sel = 2'd3; par_en = 0; two_stop = 0;
    tx_enable = 1'b1;
    write_byte(8'hA5);
    check(buf_empty == 1'b0 || rx_pos != 0, "R5 full after write", buf_empty, 0);
    wait_rx(base + 1, "R3 frame arrives");
    check_frame(base, 8'hA5, "R1 8N1 frame");
    check(buf_empty == 1'b1, "R5 empty after load", buf_empty, 1);
  endtask

  task automatic t_parity_even;
    int base = rx_cnt;
    data_bits_sel = 2'd2; par_en = 1; par_odd = 0; two_stop = 1;
    write_byte(8'h53);
    wait_rx(base + 1, "R2 even frame 1");
    check_frame(base, 8'h53, "R2 even parity 7 bits two stop");
    write_byte(8'h07);
    wait_rx(base + 2, "R2 even frame 2");
    check_frame(base + 1, 8'h07, "R2 even parity set bit");
  endtask

  task automatic t_parity_odd5;
    int base = rx_cnt;
    data_bits_sel = 2'd0; par_en = 1; par_odd = 1; two_stop = 0;
    write_byte(8'hFB);
    wait_rx(base + 1, "R2 odd frame");
    check_frame(base, 8'h1B, "R1 R2 odd parity 5 bits masked");
    cyc(16);
  endtask

  task automatic t_back_to_back;
    int base;
    data_bits_sel = 2'd3; par_en = 0; two_stop = 0;
    cyc(20);
    @(negedge clk); done_clr_wr = 1'b1;
    @(negedge clk); done_clr_wr = 1'b0;
    check(tx_done == 1'b0, "R7 write-one clear", tx_done, 0);
    base = rx_cnt;
    write_byte(8'h11);
    while (!buf_empty) @(negedge clk);
    write_byte(8'h22);
    write_byte(8'h33);
    check(buf_empty == 1'b0, "R4 held byte kept", buf_empty, 0);
    wait_rx(base + 1, "R6 first of pair");
    check(tx_done == 1'b0, "R6 no done mid pair", tx_done, 0);
    wait_rx(base + 2, "R4 second of pair");
    check(tx_done == 1'b0, "R6 no done at seam", tx_done, 0);
    cyc(30);
    check(rx_cnt == base + 2, "R4 full write dropped", rx_cnt, base + 2);
    check_frame(base, 8'h11, "R3 pair frame 1");
    check_frame(base + 1, 8'h22, "R3 pair frame 2");
    check(tx_done == 1'b1, "R6 done after pair", tx_done, 1);
  endtask

  task automatic t_done_irq;
    done_irq_en = 1'b1; global_irq_en = 1'b1;
    cyc(2);
    check(irq_done == 1'b1, "R8 irq raised", irq_done, 1);
    global_irq_en = 1'b0;
    cyc(2);
    check(irq_done == 1'b0, "R8 global gate", irq_done, 0);
    global_irq_en = 1'b1;
    cyc(2);
    @(negedge clk); done_ack = 1'b1;
    @(negedge clk); done_ack = 1'b0;
    check(tx_done == 1'b0, "R7 ack clears", tx_done, 0);
    cyc(1);
    check(irq_done == 1'b0, "R8 irq follows clear", irq_done, 0);
    done_irq_en = 1'b0; global_irq_en = 1'b0;
  endtask

  task automatic t_empty_irq;
    empty_irq_en = 1'b1; global_irq_en = 1'b1;
    cyc(2);
    check(irq_empty == 1'b1, "R9 empty level", irq_empty, 1);
    cyc(20);
    check(irq_empty == 1'b1, "R9 level persists", irq_empty, 1);
    while (tcnt != 1) @(negedge clk);
    wr_data = 8'h3C; wr_data_en = 1'b1;
    @(negedge clk); wr_data_en = 1'b0;
    cyc(1);
    check(irq_empty == 1'b0, "R9 drops on write", irq_empty, 0);
    cyc(10);
    check(irq_empty == 1'b1, "R9 back after load", irq_empty, 1);
    empty_irq_en = 1'b0;
    cyc(2);
    check(irq_empty == 1'b0, "R9 enable gate", irq_empty, 0);
    global_irq_en = 1'b0;
    cyc(120);
  endtask

  task automatic t_disable;
    int base = rx_cnt;
    int n;
    write_byte(8'h44);
    while (!buf_empty) @(negedge clk);
    write_byte(8'h55);
    tx_enable = 1'b0;
    wait_rx(base + 1, "R10 pending frame 1");
    check(txd_oe == 1'b1, "R10 oe held", txd_oe, 1);
    wait_rx(base + 2, "R10 pending frame 2");
    check(txd_oe == 1'b1, "R10 oe held to end", txd_oe, 1);
    check_frame(base + 1, 8'h55, "R10 pending byte sent");
    cyc(12);
    check(!txd_oe && txd, "R11 released", {txd_oe, txd}, 2'b01);
    write_byte(8'h66);
    check(buf_empty == 1'b1, "R4 write while off", buf_empty, 1);
    n = rx_cnt;
    cyc(120);
    check(rx_cnt == n && !txd_oe, "R4 no frame while off", rx_cnt, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_parity_even();
    t_parity_odd5();
    t_back_to_back();
    t_done_irq();
    t_empty_irq();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule